// File: doc/BRIEF.md
# Indirect Per-Bundle Reset Controller

This block keeps a transmit and a receive data-path reset state for every bundle, up to 256 of them. A host reaches it through three 32-bit register words. The command word stages a receive hold bit and a transmit hold bit. The select word names a target bundle and carries a 16-bit sequence seed. The status word reports the reset states of the bundle most recently selected. Writing the command word alone changes no bundle. Each write to the select word commits the staged command to the named bundle in that same cycle.

The datapath side sees the per-bundle hold levels and a one-cycle status-clear pulse per bundle and direction whenever a commit releases a path. It also sees a per-bundle transmit sequence counter. The counter advances on a packet-sent strobe, and it is loaded with the seed whenever a commit releases that bundle's transmit path. The counter value is the sequence number the next packet of that bundle will carry. A read port returns the counter of any one bundle.

Top module: `bundle_reset_ctrl`

## Requirements
- R1: After reset, the select, command and status words read 0, every bundle's transmit and receive paths are released (hold outputs 0), and every sequence counter reads 0.
- R2: The select word is at byte offset 0x80. Bits [7:0] hold the target bundle and bits [31:16] hold the seed. Bits [15:8] are ignored on write and read back as 0.
- R3: The command word is at offset 0x84. Bit 1 is the receive hold and bit 0 is the transmit hold, where 1 holds the path in reset and 0 releases it. Bits [31:2] read 0. A write to this word alone changes no bundle's state.
- R4: A write to the select word applies the staged receive and transmit hold bits to the bundle in bits [7:0]. The new levels appear on `tx_rst_o`/`rx_rst_o` after the clock edge of the write. Nothing else changes the hold levels.
- R5: A select-word write whose staged transmit bit is 0 loads that bundle's sequence counter with bits [31:16] of the same write. This also happens when the bundle was already released and the command is unchanged.
- R6: Each `pkt_sent` strobe for a bundle whose transmit path is released increments its counter by one, modulo 2^16.
- R7: A strobe for a bundle whose transmit path is held leaves its counter unchanged.
- R8: A commit that releases a direction drives that bundle's bit of `tx_clr_o` or `rx_clr_o` high for exactly the one cycle after the write edge. A commit that holds a direction raises no pulse for it. At most one bit of each pulse vector is high at a time.
- R9: The status word at offset 0x88 returns the selected bundle's receive hold in bit 1 and its transmit hold in bit 0, with all other bits 0.
- R10: A commit leaves the states and counters of all other bundles unchanged. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_wr_en | input | 1 | Host write strobe |
| host_addr | input | 8 | Host byte offset for reads and writes |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, combinational from `host_addr` |
| pkt_sent | input | 1 | Packet-sent strobe |
| pkt_bundle | input | 8 | Bundle the strobe refers to |
| seq_rd_bundle | input | 8 | Bundle whose counter is shown on `seq_rd_value` |
| seq_rd_value | output | 16 | Next sequence number of `seq_rd_bundle` |
| tx_rst_o | output | NUM_BUNDLES | Per-bundle transmit hold level (blocks transmission) |
| rx_rst_o | output | NUM_BUNDLES | Per-bundle receive hold level |
| tx_clr_o | output | NUM_BUNDLES | Per-bundle transmit status-clear pulse |
| rx_clr_o | output | NUM_BUNDLES | Per-bundle receive status-clear pulse |

## Verification
The checker watches several properties on every cycle. Hold levels change only on a select-word write. Clear pulses are one-hot, appear only after a commit, and a transmit release always yields exactly one transmit pulse. Reserved bits of the command and status words read zero, and a strobe to a held bundle never moves its counter. The bench scenarios cover the value-level behaviour: the seed loaded on release and on re-application of an unchanged command, counting across the 16-bit wrap, the bit layout of the select word, and whether bundles other than the one committed stay untouched.

// File: rtl/bundle_reset_pkg.sv
package bundle_reset_pkg;
  localparam int BUNDLE_W = 8;
  localparam int SEQ_W    = 16;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 8;

  localparam logic [ADDR_W-1:0] OFS_SELECT = 8'h80;
  localparam logic [ADDR_W-1:0] OFS_CMD    = 8'h84;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h88;

  // bit 1 = receive hold, bit 0 = transmit hold
  typedef struct packed {
    logic rx_hold;
    logic tx_hold;
  } path_cmd_t;
endpackage

// File: rtl/brc_rst_sync.sv
module brc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic stage0_q;
  logic stage1_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage0_q <= 1'b0;
      stage1_q <= 1'b0;
    end else begin
      stage0_q <= 1'b1;
      stage1_q <= stage0_q;
    end
  end

  assign rst_n_sync = stage1_q;
endmodule

// File: rtl/brc_host_regs.sv
module brc_host_regs
  import bundle_reset_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [BUNDLE_W-1:0] sel_q,
  output logic [SEQ_W-1:0]    seed_q,
  output path_cmd_t           cmd_q,
  output logic                commit,
  output logic [BUNDLE_W-1:0] commit_bundle,
  output logic [SEQ_W-1:0]    commit_seed
);
  logic                sel_we;
  logic                cmd_we;
  logic [BUNDLE_W-1:0] sel_d;
  logic [SEQ_W-1:0]    seed_d;
  path_cmd_t           cmd_d;
  logic                unused_wbits;

  assign sel_we = wr_en && (addr == OFS_SELECT);
  assign cmd_we = wr_en && (addr == OFS_CMD);

  // reserved write bits are dropped here
  assign unused_wbits = ^{wdata[15:8], wdata[DATA_W-1:2]};

  always_comb begin
    sel_d  = sel_q;
    seed_d = seed_q;
    cmd_d  = cmd_q;
    if (sel_we) begin
      sel_d  = wdata[BUNDLE_W-1:0];
      seed_d = wdata[DATA_W-1:DATA_W-SEQ_W];
    end
    if (cmd_we) begin
      cmd_d.rx_hold = wdata[1];
      cmd_d.tx_hold = wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      seed_q <= '0;
      cmd_q  <= '0;
    end else begin
      if (sel_we) begin
        sel_q  <= sel_d;
        seed_q <= seed_d;
      end
      if (cmd_we) begin
        cmd_q <= cmd_d;
      end
    end
  end

  assign commit        = sel_we;
  assign commit_bundle = wdata[BUNDLE_W-1:0];
  assign commit_seed   = wdata[DATA_W-1:DATA_W-SEQ_W];
endmodule

// File: rtl/brc_path_state.sv
module brc_path_state
  import bundle_reset_pkg::*;
#(
  parameter int NUM_BUNDLES = 256
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   commit,
  input  logic [BUNDLE_W-1:0]    commit_bundle,
  input  path_cmd_t              cmd,
  output logic [NUM_BUNDLES-1:0] tx_hold,
  output logic [NUM_BUNDLES-1:0] rx_hold,
  output logic [NUM_BUNDLES-1:0] tx_clr,
  output logic [NUM_BUNDLES-1:0] rx_clr
);
  for (genvar i = 0; i < NUM_BUNDLES; i++) begin : g_bundle
    logic hit;
    logic tx_d, rx_d, txc_d, rxc_d;

    assign hit = commit && (commit_bundle == BUNDLE_W'(i));

    always_comb begin
      tx_d  = tx_hold[i];
      rx_d  = rx_hold[i];
      txc_d = 1'b0;
      rxc_d = 1'b0;
      if (hit) begin
        tx_d  = cmd.tx_hold;
        rx_d  = cmd.rx_hold;
        txc_d = !cmd.tx_hold;
        rxc_d = !cmd.rx_hold;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tx_hold[i] <= 1'b0;
        rx_hold[i] <= 1'b0;
        tx_clr[i]  <= 1'b0;
        rx_clr[i]  <= 1'b0;
      end else begin
        if (hit) begin
          tx_hold[i] <= tx_d;
          rx_hold[i] <= rx_d;
        end
        tx_clr[i] <= txc_d;
        rx_clr[i] <= rxc_d;
      end
    end
  end
endmodule

// File: rtl/brc_seq_bank.sv
module brc_seq_bank
  import bundle_reset_pkg::*;
#(
  parameter int NUM_BUNDLES = 256
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   commit,
  input  logic [BUNDLE_W-1:0]    commit_bundle,
  input  logic                   cmd_tx_hold,
  input  logic [SEQ_W-1:0]       commit_seed,
  input  logic [NUM_BUNDLES-1:0] tx_hold,
  input  logic                   pkt_sent,
  input  logic [BUNDLE_W-1:0]    pkt_bundle,
  input  logic [BUNDLE_W-1:0]    rd_bundle,
  output logic [SEQ_W-1:0]       rd_value
);
  logic [SEQ_W-1:0] cnt_q [NUM_BUNDLES];

  for (genvar i = 0; i < NUM_BUNDLES; i++) begin : g_cnt
    logic             load, adv, en;
    logic [SEQ_W-1:0] cnt_d;

    assign load = commit && (commit_bundle == BUNDLE_W'(i)) && !cmd_tx_hold;
    assign adv  = pkt_sent && (pkt_bundle == BUNDLE_W'(i)) && !tx_hold[i];
    assign en   = load || adv;

    always_comb begin
      if (load) cnt_d = commit_seed;
      else      cnt_d = cnt_q[i] + SEQ_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q[i] <= '0;
      end else if (en) begin
        cnt_q[i] <= cnt_d;
      end
    end
  end

  always_comb begin
    rd_value = '0;
    for (int k = 0; k < NUM_BUNDLES; k++) begin
      if (rd_bundle == BUNDLE_W'(k)) rd_value = cnt_q[k];
    end
  end
endmodule

// File: rtl/bundle_reset_ctrl.sv
module bundle_reset_ctrl
  import bundle_reset_pkg::*;
#(
  parameter int NUM_BUNDLES = 256
) (
  input  logic                   clk,
  input  logic                   arst_n,
  input  logic                   host_wr_en,
  input  logic [ADDR_W-1:0]      host_addr,
  input  logic [DATA_W-1:0]      host_wdata,
  output logic [DATA_W-1:0]      host_rdata,
  input  logic                   pkt_sent,
  input  logic [BUNDLE_W-1:0]    pkt_bundle,
  input  logic [BUNDLE_W-1:0]    seq_rd_bundle,
  output logic [SEQ_W-1:0]       seq_rd_value,
  output logic [NUM_BUNDLES-1:0] tx_rst_o,
  output logic [NUM_BUNDLES-1:0] rx_rst_o,
  output logic [NUM_BUNDLES-1:0] tx_clr_o,
  output logic [NUM_BUNDLES-1:0] rx_clr_o
);
  logic                rst_n_s;
  logic [BUNDLE_W-1:0] sel_q;
  logic [SEQ_W-1:0]    seed_q;
  path_cmd_t           cmd_q;
  logic                commit;
  logic [BUNDLE_W-1:0] commit_bundle;
  logic [SEQ_W-1:0]    commit_seed;
  path_cmd_t           sel_state;

  brc_rst_sync u_rst (
    .clk        (clk),
    .arst_n     (arst_n),
    .rst_n_sync (rst_n_s)
  );

  brc_host_regs u_regs (
    .clk           (clk),
    .rst_n         (rst_n_s),
    .wr_en         (host_wr_en),
    .addr          (host_addr),
    .wdata         (host_wdata),
    .sel_q         (sel_q),
    .seed_q        (seed_q),
    .cmd_q         (cmd_q),
    .commit        (commit),
    .commit_bundle (commit_bundle),
    .commit_seed   (commit_seed)
  );

  brc_path_state #(.NUM_BUNDLES(NUM_BUNDLES)) u_state (
    .clk           (clk),
    .rst_n         (rst_n_s),
    .commit        (commit),
    .commit_bundle (commit_bundle),
    .cmd           (cmd_q),
    .tx_hold       (tx_rst_o),
    .rx_hold       (rx_rst_o),
    .tx_clr        (tx_clr_o),
    .rx_clr        (rx_clr_o)
  );

  brc_seq_bank #(.NUM_BUNDLES(NUM_BUNDLES)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n_s),
    .commit        (commit),
    .commit_bundle (commit_bundle),
    .cmd_tx_hold   (cmd_q.tx_hold),
    .commit_seed   (commit_seed),
    .tx_hold       (tx_rst_o),
    .pkt_sent      (pkt_sent),
    .pkt_bundle    (pkt_bundle),
    .rd_bundle     (seq_rd_bundle),
    .rd_value      (seq_rd_value)
  );

  // reset state of the selected bundle
  always_comb begin
    sel_state = '0;
    for (int k = 0; k < NUM_BUNDLES; k++) begin
      if (sel_q == BUNDLE_W'(k)) begin
        sel_state.rx_hold = rx_rst_o[k];
        sel_state.tx_hold = tx_rst_o[k];
      end
    end
  end

  always_comb begin
    unique case (host_addr)
      OFS_SELECT: host_rdata = {seed_q, 8'h00, sel_q};
      OFS_CMD:    host_rdata = {30'd0, cmd_q};
      OFS_STATUS: host_rdata = {30'd0, sel_state};
      default:    host_rdata = '0;
    endcase
  end
endmodule

// File: rtl/bundle_reset_ctrl_chk.sv
module bundle_reset_ctrl_chk
  import bundle_reset_pkg::*;
#(
  parameter int NUM_BUNDLES = 256
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   host_wr_en,
  input logic [ADDR_W-1:0]      host_addr,
  input logic [DATA_W-1:0]      host_wdata,
  input logic [DATA_W-1:0]      host_rdata,
  input logic                   staged_tx,
  input logic                   pkt_sent,
  input logic [BUNDLE_W-1:0]    pkt_bundle,
  input logic [BUNDLE_W-1:0]    seq_rd_bundle,
  input logic [SEQ_W-1:0]       seq_rd_value,
  input logic [NUM_BUNDLES-1:0] tx_hold,
  input logic [NUM_BUNDLES-1:0] rx_hold,
  input logic [NUM_BUNDLES-1:0] tx_clr,
  input logic [NUM_BUNDLES-1:0] rx_clr
);
  logic sel_wr;
  logic tx_release_wr;
  logic pkt_to_held;

  assign sel_wr        = host_wr_en && (host_addr == OFS_SELECT);
  assign tx_release_wr = sel_wr && !staged_tx &&
                         (32'(host_wdata[BUNDLE_W-1:0]) < NUM_BUNDLES);

  always_comb begin
    pkt_to_held = 1'b0;
    for (int k = 0; k < NUM_BUNDLES; k++) begin
      if (pkt_sent && pkt_bundle == BUNDLE_W'(k) && tx_hold[k]) pkt_to_held = 1'b1;
    end
  end

  assert_hold_only_on_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_wr |=> ($stable(tx_hold) && $stable(rx_hold)));

  assert_clr_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tx_clr) && $onehot0(rx_clr));

  assert_tx_release_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_release_wr |=> ($countones(tx_clr) == 1));

  assert_no_pulse_without_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_wr |=> (tx_clr == '0 && rx_clr == '0));

  assert_cmd_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == OFS_CMD) |-> (host_rdata[DATA_W-1:2] == '0));

  assert_status_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == OFS_STATUS) |-> (host_rdata[DATA_W-1:2] == '0));

  assert_held_no_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_to_held && !sel_wr && seq_rd_bundle == pkt_bundle) |=>
      ((seq_rd_bundle != $past(seq_rd_bundle)) || $stable(seq_rd_value)));
endmodule

bind bundle_reset_ctrl bundle_reset_ctrl_chk #(.NUM_BUNDLES(NUM_BUNDLES)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n_s),
  .host_wr_en    (host_wr_en),
  .host_addr     (host_addr),
  .host_wdata    (host_wdata),
  .host_rdata    (host_rdata),
  .staged_tx     (cmd_q.tx_hold),
  .pkt_sent      (pkt_sent),
  .pkt_bundle    (pkt_bundle),
  .seq_rd_bundle (seq_rd_bundle),
  .seq_rd_value  (seq_rd_value),
  .tx_hold       (tx_rst_o),
  .rx_hold       (rx_rst_o),
  .tx_clr        (tx_clr_o),
  .rx_clr        (rx_clr_o)
);

// File: tb/bundle_reset_ctrl_test.sv
module bundle_reset_ctrl_test;
  localparam int NB = 256;

  logic          clk = 1'b0;
  logic          arst_n;
  logic          host_wr_en;
  logic [7:0]    host_addr;
  logic [31:0]   host_wdata;
  logic [31:0]   host_rdata;
  logic          pkt_sent;
  logic [7:0]    pkt_bundle;
  logic [7:0]    seq_rd_bundle;
  logic [15:0]   seq_rd_value;
  logic [NB-1:0] tx_rst_o, rx_rst_o, tx_clr_o, rx_clr_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  bundle_reset_ctrl #(.NUM_BUNDLES(NB)) uut (
    .clk(clk), .arst_n(arst_n), .host_wr_en(host_wr_en), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .pkt_sent(pkt_sent),
    .pkt_bundle(pkt_bundle), .seq_rd_bundle(seq_rd_bundle), .seq_rd_value(seq_rd_value),
    .tx_rst_o(tx_rst_o), .rx_rst_o(rx_rst_o), .tx_clr_o(tx_clr_o), .rx_clr_o(rx_clr_o)
  );

  // {cmd[1:0], bundle, seed, packets, expected status[1:0], expected next seq}
  localparam int NV = 6;
  localparam logic [47:0] VEC [NV] = '{
    {2'b00, 8'h05, 16'h1234, 4'd3, 2'b00, 16'h1237},
    {2'b01, 8'h05, 16'hAAAA, 4'd2, 2'b01, 16'h1237},
    {2'b10, 8'h09, 16'h0100, 4'd1, 2'b10, 16'h0101},
    {2'b11, 8'h09, 16'h0000, 4'd4, 2'b11, 16'h0101},
    {2'b00, 8'hFF, 16'hFFFE, 4'd3, 2'b00, 16'h0001},
    {2'b00, 8'h05, 16'h0042, 4'd0, 2'b00, 16'h0042}
  };

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    host_wr_en = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr_en = 1'b0; host_wdata = '0;
  endtask

  task automatic host_read(input logic [7:0] a, output logic [31:0] d);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic send_pkt(input logic [7:0] b);
    @(negedge clk);
    pkt_sent = 1'b1; pkt_bundle = b;
    @(negedge clk);
    pkt_sent = 1'b0;
  endtask

  task automatic read_seq(input logic [7:0] b, output logic [15:0] v);
    seq_rd_bundle = b;
    #1 v = seq_rd_value;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [15:0] sq;
    logic [NB-1:0] tx_snap, rx_snap;
    arst_n = 1'b0; host_wr_en = 1'b0; host_addr = '0; host_wdata = '0;
    pkt_sent = 1'b0; pkt_bundle = '0; seq_rd_bundle = '0;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    host_read(8'h80, rd); check("R1 select", 256'(rd), 256'(0));
    host_read(8'h84, rd); check("R1 command", 256'(rd), 256'(0));
    host_read(8'h88, rd); check("R1 status", 256'(rd), 256'(0));
    check("R1 tx hold", 256'(tx_rst_o), 256'(0));
    check("R1 rx hold", 256'(rx_rst_o), 256'(0));
    read_seq(8'd0, sq);   check("R1 seq 0", 256'(sq), 256'(0));
    read_seq(8'd255, sq); check("R1 seq 255", 256'(sq), 256'(0));

    // table walk: R4 R5 R6 R7 R9
    for (int v = 0; v < NV; v++) begin
      logic [47:0] e;
      e = VEC[v];
      host_write(8'h84, {30'd0, e[47:46]});
      host_write(8'h80, {e[37:22], 8'h00, e[45:38]});
      for (int p = 0; p < int'(e[21:18]); p++) send_pkt(e[45:38]);
      host_read(8'h88, rd);
      check($sformatf("R9 R4 status vector %0d", v), 256'(rd), 256'(e[17:16]));
      read_seq(e[45:38], sq);
      check($sformatf("R5 R6 R7 seq vector %0d", v), 256'(sq), 256'(e[15:0]));
    end

    // R8 transmit release with receive hold
    host_write(8'h84, 32'h2);
    host_write(8'h80, {16'h0BEE, 8'h00, 8'd20});
    check("R8 tx pulse", 256'(tx_clr_o), 256'(1) << 20);
    check("R8 no rx pulse on hold", 256'(rx_clr_o), 256'(0));
    @(negedge clk);
    check("R8 tx pulse one cycle", 256'(tx_clr_o), 256'(0));
    host_write(8'h84, 32'h1);
    host_write(8'h80, {16'h0BEE, 8'h00, 8'd20});
    check("R8 rx pulse", 256'(rx_clr_o), 256'(1) << 20);
    check("R8 no tx pulse on hold", 256'(tx_clr_o), 256'(0));

    // R3 staging alone has no effect
    host_write(8'h84, 32'hFFFF_FFFF);
    host_read(8'h84, rd); check("R3 reserved cmd bits", 256'(rd), 256'(3));
    check("R3 staging no tx change", 256'(tx_rst_o[20]), 256'(1));
    check("R3 staging no rx change", 256'(rx_rst_o[20]), 256'(0));

    // R2 layout and R10 isolation
    tx_snap = tx_rst_o; rx_snap = rx_rst_o;
    host_write(8'h80, 32'hABCD_FF07);
    host_read(8'h80, rd); check("R2 select readback", 256'(rd), 256'(32'hABCD_0007));
    host_read(8'h88, rd); check("R9 status bundle 7", 256'(rd), 256'(3));
    tx_snap[7] = 1'b1; rx_snap[7] = 1'b1;
    check("R10 tx others unchanged", 256'(tx_rst_o), 256'(tx_snap));
    check("R10 rx others unchanged", 256'(rx_rst_o), 256'(rx_snap));
    read_seq(8'd7, sq); check("R5 no seed on hold", 256'(sq), 256'(0));
    read_seq(8'd9, sq); check("R10 seq other bundle", 256'(sq), 256'(16'h0101));

    // R5 re-applying an unchanged release reseeds
    host_write(8'h84, 32'h0);
    host_write(8'h80, {16'h7777, 8'h00, 8'd5});
    check("R8 pulse on re-release", 256'(tx_clr_o), 256'(1) << 5);
    read_seq(8'd5, sq); check("R5 reseed unchanged cmd", 256'(sq), 256'(16'h7777));
    send_pkt(8'd5);
    read_seq(8'd5, sq); check("R6 count after reseed", 256'(sq), 256'(16'h7778));

    host_read(8'h90, rd); check("R10 unmapped read", 256'(rd), 256'(0));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule